// File: doc/BRIEF.md
# DRAM Low-Power Mode Sequencer

This block sits between the request path of a memory controller and its DRAM command issuer. It decides when an SDRAM device is put into self-refresh or power-down and how it is brought back out. A programmable idle delay, measured from the end of the last transfer, sets when entry happens. An access that arrives while the device sleeps wakes it, and the block returns to the same low-power mode once the device has been idle again for the programmed delay. A self-refresh exit waits a fixed recovery time and then asks for either an auto-refresh or an activate. Outside self-refresh the block keeps periodic auto-refresh going. If an extended-mode-register update is waiting and the bus is not shared, a mode-register load is placed just before the self-refresh entry command.

The sequencer is a single state machine with these states: AWAKE (device usable, idle counter running), REFRESH (periodic auto-refresh pulse), MRS (mode-register load pulse), SR_ENTER (self-refresh entry pulse), SELF_REF (device in self-refresh), SR_EXIT (exit pulse), XSNR_WAIT (recovery wait), POST (auto-refresh or activate pulse), PD_ENTER (power-down entry pulse), POWER_DOWN (device in power-down) and PD_EXIT (exit pulse). The transitions are: AWAKE to REFRESH when refresh is due and nothing is active; AWAKE to MRS or SR_ENTER when the idle delay has run out in self-refresh mode; AWAKE to PD_ENTER when it has run out in power-down mode; MRS to SR_ENTER; SR_ENTER to SELF_REF; SELF_REF to SR_EXIT on a pending access; SR_EXIT to XSNR_WAIT; XSNR_WAIT to POST when recovery is complete; PD_ENTER to POWER_DOWN; POWER_DOWN to PD_EXIT on a pending access or a due refresh. REFRESH, POST and PD_EXIT always go back to AWAKE. Every command output is a one-cycle pulse that is high exactly in the cycle its state is held.

Top module: `lp_sequencer`

## Requirements
- R1: With `xfer_busy` and `access_pending` both low, the entry command is asserted after N complete idle cycles, in the cycle that follows them. N is 0 for timeout code 0, IDLE_SHORT (64) for code 1 and IDLE_LONG (128) for code 2. Code 3 acts as code 0.
- R2: Mode code 0 and code 3 never produce an entry command (`cmd_sr_enter`, `cmd_pd_enter`, `cmd_mrs_load`), and `cke` stays 1. Code 1 selects self-refresh and code 2 selects power-down.
- R3: Self-refresh entry pulses `cmd_sr_enter` for one cycle. From the next cycle on, `cke` and `clk_en` are 0 until exit. At most one command output is high in any cycle.
- R4: Power-down entry pulses `cmd_pd_enter` for one cycle. From the next cycle on, `cke` is 0 and `clk_en` stays 1 when `cfg_clk_freeze` is 0.
- R5: In either low-power state, `access_pending` pulses `cmd_exit` in the following cycle, and `cke` returns to 1. Once the device is idle again, the same mode is re-entered after the same delay as in R1.
- R6: After a self-refresh `cmd_exit`, exactly T_XSNR cycles pass. In the cycle after them, `cmd_refresh` pulses if `cfg_exit_refresh` is 1, or `cmd_activate` pulses if it is 0.
- R7: With `cfg_clk_freeze` = 1, `clk_en` is 0 for every cycle the device is in power-down and returns to 1 with the exit.
- R8: `sr_done` is 1 only while the device is in self-refresh. It is 0 in the entry cycle and from the exit cycle on.
- R9: When `cfg_upd_policy` is 2 and `emr_update_pending` is 1 at the entry decision, `cmd_mrs_load` pulses in the cycle just before `cmd_sr_enter`. Under any other policy, no load is issued.
- R10: Outside self-refresh, `cmd_refresh` pulses every REFI_CYCLES cycles while the device is idle. The first pulse after reset comes no later than REFI_CYCLES cycles.
- R11: A new transfer (`xfer_busy` or `access_pending` high) restarts the idle count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Low-power mode: 0 none, 1 self-refresh, 2 power-down, 3 none |
| cfg_timeout | input | 2 | Idle delay code: 0 none, 1 short, 2 long, 3 as 0 |
| cfg_clk_freeze | input | 1 | Hold the memory clock off during power-down |
| cfg_exit_refresh | input | 1 | After self-refresh exit: 1 auto-refresh, 0 activate |
| cfg_upd_policy | input | 2 | Mode-register update policy; 2 means update before self-refresh entry |
| emr_update_pending | input | 1 | An extended-mode-register change waits to be written |
| access_pending | input | 1 | An access request is queued |
| xfer_busy | input | 1 | A data transfer is in progress |
| cmd_sr_enter | output | 1 | Self-refresh entry command request |
| cmd_pd_enter | output | 1 | Power-down entry command request |
| cmd_exit | output | 1 | Low-power exit command request |
| cmd_refresh | output | 1 | Auto-refresh command request |
| cmd_activate | output | 1 | Activate command request |
| cmd_mrs_load | output | 1 | Mode-register load command request |
| cke | output | 1 | Clock-enable level for the device |
| clk_en | output | 1 | Memory clock gate enable |
| sr_done | output | 1 | Device is in self-refresh |

## Verification
The bench goes after the exact entry cycle for each timeout code and after an off-by-one in the idle count. A design that gets this wrong issues its entry command one cycle early or late, or uses the short delay where the long one is selected. It also checks that a one-cycle transfer in the middle of the count restarts it. A design that only paused the count would enter too early. The self-refresh exit is timed to the cycle, so a recovery wait one cycle short or long, or a swapped refresh/activate choice, shows up as a mismatched scoreboard item. Other targets are a mode-register load issued in the wrong cycle or under the wrong policy, entry commands under the disabled mode codes, a clock that runs when it should be frozen, and a periodic refresh interval that drifts.

// File: rtl/lp_pkg.sv
package lp_pkg;

    typedef enum logic [3:0] {
        ST_AWAKE,
        ST_REFRESH,
        ST_MRS,
        ST_SR_ENTER,
        ST_SELF_REF,
        ST_SR_EXIT,
        ST_XSNR_WAIT,
        ST_POST,
        ST_PD_ENTER,
        ST_POWER_DOWN,
        ST_PD_EXIT
    } lp_state_e;

    typedef enum logic [1:0] {
        LPM_NONE = 2'd0,
        LPM_SR   = 2'd1,
        LPM_PD   = 2'd2
    } lp_mode_e;

    localparam logic [1:0] UPD_BEFORE_SR = 2'd2;

    // Reserved mode code folds onto "no low power".
    function automatic lp_mode_e decode_mode(input logic [1:0] code);
        unique case (code)
            2'd1:    return LPM_SR;
            2'd2:    return LPM_PD;
            default: return LPM_NONE;
        endcase
    endfunction

endpackage

// File: rtl/lp_idle_timer.sv
module lp_idle_timer #(
    parameter int SHORT_CYC = 64,
    parameter int LONG_CYC  = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       activity,
    input  logic [1:0] tmo_code,
    output logic       ready
);
    localparam int CW = $clog2(LONG_CYC + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    // Reserved code 3 behaves like code 0.
    always_comb begin
        unique case (tmo_code)
            2'd1:    limit = CW'(SHORT_CYC);
            2'd2:    limit = CW'(LONG_CYC);
            default: limit = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || activity) begin
            cnt <= '0;
        end else if (cnt != CW'(LONG_CYC)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign ready = run && !activity && (cnt >= limit);

    // R1: the idle count saturates at the long delay
    assert_idle_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LONG_CYC));

    // R11: activity restarts the count
    assert_idle_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        activity |=> (cnt == '0));

endmodule

// File: rtl/lp_refresh_timer.sv
module lp_refresh_timer #(
    parameter int REFI_CYCLES = 3900
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic clear,
    output logic due
);
    localparam int CW = $clog2(REFI_CYCLES);
    localparam logic [CW-1:0] DUE_AT = CW'(REFI_CYCLES - 2);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (hold || clear) begin
            cnt <= '0;
        end else if (!due) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign due = (cnt >= DUE_AT);

    // R10: the interval counter never runs past its due point
    assert_refi_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= DUE_AT);

endmodule

// File: rtl/lp_exit_timer.sv
module lp_exit_timer #(
    parameter int T_XSNR = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(T_XSNR + 1);
    localparam logic [CW-1:0] LAST = CW'(T_XSNR - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= '0;
        end else if (run && !done) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == LAST);

    // R6: the wait advances by one each running cycle
    assert_xsnr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !done) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/lp_sequencer.sv
module lp_sequencer
    import lp_pkg::*;
#(
    parameter int IDLE_SHORT  = 64,
    parameter int IDLE_LONG   = 128,
    parameter int T_XSNR      = 8,
    parameter int REFI_CYCLES = 3900
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_mode,
    input  logic [1:0] cfg_timeout,
    input  logic       cfg_clk_freeze,
    input  logic       cfg_exit_refresh,
    input  logic [1:0] cfg_upd_policy,
    input  logic       emr_update_pending,
    input  logic       access_pending,
    input  logic       xfer_busy,
    output logic       cmd_sr_enter,
    output logic       cmd_pd_enter,
    output logic       cmd_exit,
    output logic       cmd_refresh,
    output logic       cmd_activate,
    output logic       cmd_mrs_load,
    output logic       cke,
    output logic       clk_en,
    output logic       sr_done
);
    lp_state_e state, state_nx;
    lp_mode_e  mode_eff;
    logic      activity;
    logic      idle_ready;
    logic      ref_due;
    logic      xsnr_done;

    assign mode_eff = decode_mode(cfg_mode);
    assign activity = xfer_busy || access_pending;

    lp_idle_timer #(
        .SHORT_CYC (IDLE_SHORT),
        .LONG_CYC  (IDLE_LONG)
    ) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state == ST_AWAKE),
        .activity (activity),
        .tmo_code (cfg_timeout),
        .ready    (idle_ready)
    );

    lp_refresh_timer #(
        .REFI_CYCLES (REFI_CYCLES)
    ) u_refi (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (state == ST_SELF_REF),
        .clear (cmd_refresh),
        .due   (ref_due)
    );

    lp_exit_timer #(
        .T_XSNR (T_XSNR)
    ) u_xsnr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (state == ST_SR_EXIT),
        .run   (state == ST_XSNR_WAIT),
        .done  (xsnr_done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_AWAKE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_AWAKE: begin
                if (!activity && ref_due) begin
                    state_nx = ST_REFRESH;
                end else if (idle_ready && mode_eff == LPM_SR) begin
                    state_nx = (cfg_upd_policy == UPD_BEFORE_SR && emr_update_pending)
                               ? ST_MRS : ST_SR_ENTER;
                end else if (idle_ready && mode_eff == LPM_PD) begin
                    state_nx = ST_PD_ENTER;
                end
            end
            ST_REFRESH:    state_nx = ST_AWAKE;
            ST_MRS:        state_nx = ST_SR_ENTER;
            ST_SR_ENTER:   state_nx = ST_SELF_REF;
            ST_SELF_REF:   if (access_pending) state_nx = ST_SR_EXIT;
            ST_SR_EXIT:    state_nx = ST_XSNR_WAIT;
            ST_XSNR_WAIT:  if (xsnr_done) state_nx = ST_POST;
            ST_POST:       state_nx = ST_AWAKE;
            ST_PD_ENTER:   state_nx = ST_POWER_DOWN;
            ST_POWER_DOWN: if (access_pending || ref_due) state_nx = ST_PD_EXIT;
            ST_PD_EXIT:    state_nx = ST_AWAKE;
            default:       state_nx = ST_AWAKE;
        endcase
    end

    always_comb begin
        cmd_sr_enter = 1'b0;
        cmd_pd_enter = 1'b0;
        cmd_exit     = 1'b0;
        cmd_refresh  = 1'b0;
        cmd_activate = 1'b0;
        cmd_mrs_load = 1'b0;
        cke          = 1'b1;
        clk_en       = 1'b1;
        sr_done      = 1'b0;
        unique case (state)
            ST_REFRESH:  cmd_refresh  = 1'b1;
            ST_MRS:      cmd_mrs_load = 1'b1;
            ST_SR_ENTER: cmd_sr_enter = 1'b1;
            ST_SELF_REF: begin
                cke     = 1'b0;
                clk_en  = 1'b0;
                sr_done = 1'b1;
            end
            ST_SR_EXIT:  cmd_exit     = 1'b1;
            ST_POST: begin
                cmd_refresh  = cfg_exit_refresh;
                cmd_activate = !cfg_exit_refresh;
            end
            ST_PD_ENTER: cmd_pd_enter = 1'b1;
            ST_POWER_DOWN: begin
                cke    = 1'b0;
                clk_en = !cfg_clk_freeze;
            end
            ST_PD_EXIT:  cmd_exit     = 1'b1;
            default: ;
        endcase
    end

    // R3: command requests never overlap
    assert_one_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_sr_enter, cmd_pd_enter, cmd_exit, cmd_refresh, cmd_activate, cmd_mrs_load}));

    // R2: disabled mode issues no entry
    assert_no_entry_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AWAKE && mode_eff == LPM_NONE) |=> !(cmd_sr_enter || cmd_pd_enter || cmd_mrs_load));

    // R6: post-exit command only right after the recovery wait
    assert_post_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_activate |-> ($past(state) == ST_XSNR_WAIT && $past(xsnr_done)));

    // R7: frozen clock while cke is low outside self-refresh
    assert_clk_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && !sr_done && cfg_clk_freeze) |-> !clk_en);

    // R8: self-refresh status only ends through an exit
    assert_sr_done_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sr_done |=> (sr_done || cmd_exit));

    // R9: a pending update under policy 2 goes out before entry
    assert_mrs_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_sr_enter |-> ($past(state) == ST_MRS ||
                          !($past(cfg_upd_policy) == UPD_BEFORE_SR && $past(emr_update_pending))));

endmodule

// File: tb/test_lp_sequencer.sv
`timescale 1ns/1ps
module test_lp_sequencer;

    localparam int IDLE_SHORT  = 64;
    localparam int IDLE_LONG   = 128;
    localparam int T_XSNR      = 8;
    localparam int REFI_CYCLES = 3900;

    localparam int K_SRE = 0, K_PDE = 1, K_EXIT = 2, K_REF = 3, K_ACT = 4, K_MRS = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic [1:0] cfg_timeout = 2'd0;
    logic       cfg_clk_freeze = 1'b0;
    logic       cfg_exit_refresh = 1'b0;
    logic [1:0] cfg_upd_policy = 2'd0;
    logic       emr_update_pending = 1'b0;
    logic       access_pending = 1'b0;
    logic       xfer_busy = 1'b0;
    logic       cmd_sr_enter, cmd_pd_enter, cmd_exit, cmd_refresh, cmd_activate, cmd_mrs_load;
    logic       cke, clk_en, sr_done;

    always #2 clk = ~clk;

    lp_sequencer #(
        .IDLE_SHORT  (IDLE_SHORT),
        .IDLE_LONG   (IDLE_LONG),
        .T_XSNR      (T_XSNR),
        .REFI_CYCLES (REFI_CYCLES)
    ) i_lp_sequencer (
        .clk                (clk),
        .rst_n              (rst_n),
        .cfg_mode           (cfg_mode),
        .cfg_timeout        (cfg_timeout),
        .cfg_clk_freeze     (cfg_clk_freeze),
        .cfg_exit_refresh   (cfg_exit_refresh),
        .cfg_upd_policy     (cfg_upd_policy),
        .emr_update_pending (emr_update_pending),
        .access_pending     (access_pending),
        .xfer_busy          (xfer_busy),
        .cmd_sr_enter       (cmd_sr_enter),
        .cmd_pd_enter       (cmd_pd_enter),
        .cmd_exit           (cmd_exit),
        .cmd_refresh        (cmd_refresh),
        .cmd_activate       (cmd_activate),
        .cmd_mrs_load       (cmd_mrs_load),
        .cke                (cke),
        .clk_en             (clk_en),
        .sr_done            (sr_done)
    );

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    bit    sb_on = 1'b1;
    bit    finished = 1'b0;
    int    exp_kind[$];
    int    exp_cyc[$];
    string exp_tag[$];
    int    ref_seen[$];

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic expect_cmd(int kind, int at, string tag);
        exp_kind.push_back(kind);
        exp_cyc.push_back(at);
        exp_tag.push_back(tag);
    endtask

    task automatic goto_cyc(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic drained(string tag);
        check({tag, " leftover expected commands"}, exp_kind.size(), 0);
        exp_kind.delete(); exp_cyc.delete(); exp_tag.delete();
    endtask

    // Monitor: pop expected commands as the design emits them
    always begin
        @(posedge clk);
        cyc++;
        #1;
        if (rst_n) begin
            logic [5:0] seen;
            seen = {cmd_mrs_load, cmd_activate, cmd_refresh, cmd_exit, cmd_pd_enter, cmd_sr_enter};
            if (!sb_on) begin
                if (cmd_refresh) ref_seen.push_back(cyc);
            end else begin
                for (int k = 0; k < 6; k++) begin
                    if (seen[k]) begin
                        if (exp_kind.size() == 0) begin
                            check("unexpected command kind", k, -1);
                        end else begin
                            int    ek, ec;
                            string et;
                            ek = exp_kind.pop_front();
                            ec = exp_cyc.pop_front();
                            et = exp_tag.pop_front();
                            check({et, " command kind"}, k, ek);
                            check({et, " command cycle"}, cyc, ec);
                        end
                    end
                end
            end
        end
    end

    task automatic do_reset(bit busy);
        rst_n = 1'b0;
        xfer_busy = busy;
        access_pending = 1'b0;
        emr_update_pending = 1'b0;
        repeat (3) @(negedge clk);
        check("R3 reset cke", cke, 1);
        check("R3 reset clk_en", clk_en, 1);
        check("R8 reset sr_done", sr_done, 0);
        check("R3 reset commands",
              {cmd_sr_enter, cmd_pd_enter, cmd_exit, cmd_refresh, cmd_activate, cmd_mrs_load}, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        int k, m, p, k2;

        // Test A: self-refresh, timeout 0, exit with auto-refresh
        cfg_mode = 2'd1; cfg_timeout = 2'd0; cfg_exit_refresh = 1'b1; cfg_upd_policy = 2'd0;
        do_reset(1'b1);
        @(negedge clk); k = cyc; xfer_busy = 1'b0;
        expect_cmd(K_SRE, k + 1, "R1 R3 immediate entry");
        goto_cyc(k + 2);
        check("R3 cke low in self-refresh", cke, 0);
        check("R3 clock off in self-refresh", clk_en, 0);
        check("R8 sr_done in self-refresh", sr_done, 1);
        goto_cyc(k + 8);
        m = cyc; access_pending = 1'b1;
        expect_cmd(K_EXIT, m + 1, "R5 wake from self-refresh");
        expect_cmd(K_REF, m + 2 + T_XSNR, "R6 auto-refresh after recovery");
        goto_cyc(m + 1);
        check("R8 sr_done clears on exit", sr_done, 0);
        goto_cyc(m + 3 + T_XSNR);
        check("R5 cke high after exit", cke, 1);
        p = cyc; access_pending = 1'b0;
        expect_cmd(K_SRE, p + 1, "R5 re-entry self-refresh");
        goto_cyc(p + 2);
        check("R5 back in self-refresh", sr_done, 1);
        drained("R5");

        // Test B: timeout 64, exit with activate
        cfg_timeout = 2'd1; cfg_exit_refresh = 1'b0;
        do_reset(1'b1);
        @(negedge clk); k = cyc; xfer_busy = 1'b0;
        expect_cmd(K_SRE, k + IDLE_SHORT + 1, "R1 short delay entry");
        goto_cyc(k + IDLE_SHORT + 2);
        m = cyc; access_pending = 1'b1;
        expect_cmd(K_EXIT, m + 1, "R5 wake");
        expect_cmd(K_ACT, m + 2 + T_XSNR, "R6 activate after recovery");
        goto_cyc(m + 3 + T_XSNR);
        drained("R6");

        // Test C: power-down, timeout 128, clock running
        cfg_mode = 2'd2; cfg_timeout = 2'd2; cfg_clk_freeze = 1'b0;
        do_reset(1'b1);
        @(negedge clk); k = cyc; xfer_busy = 1'b0;
        expect_cmd(K_PDE, k + IDLE_LONG + 1, "R1 long delay entry");
        goto_cyc(k + IDLE_LONG + 2);
        check("R4 cke low in power-down", cke, 0);
        check("R4 clock runs in power-down", clk_en, 1);
        check("R8 no sr_done in power-down", sr_done, 0);
        m = cyc; access_pending = 1'b1;
        expect_cmd(K_EXIT, m + 1, "R5 wake from power-down");
        goto_cyc(m + 2);
        check("R5 cke high after power-down exit", cke, 1);
        p = cyc; access_pending = 1'b0;
        expect_cmd(K_PDE, p + IDLE_LONG + 1, "R5 re-entry power-down");
        goto_cyc(p + IDLE_LONG + 2);
        check("R5 back in power-down", cke, 0);
        drained("R4");

        // Test D: power-down with clock freeze
        cfg_timeout = 2'd0; cfg_clk_freeze = 1'b1;
        do_reset(1'b1);
        @(negedge clk); k = cyc; xfer_busy = 1'b0;
        expect_cmd(K_PDE, k + 1, "R7 entry");
        goto_cyc(k + 2);
        check("R7 clock frozen first cycle", clk_en, 0);
        goto_cyc(k + 20);
        check("R7 clock frozen later", clk_en, 0);
        m = cyc; access_pending = 1'b1;
        expect_cmd(K_EXIT, m + 1, "R7 exit");
        goto_cyc(m + 2);
        check("R7 clock back after exit", clk_en, 1);
        access_pending = 1'b1;
        drained("R7");

        // Test E: transfer in mid-count restarts idle time
        cfg_mode = 2'd1; cfg_timeout = 2'd1; cfg_clk_freeze = 1'b0;
        do_reset(1'b1);
        @(negedge clk); k = cyc; xfer_busy = 1'b0;
        goto_cyc(k + 30);
        xfer_busy = 1'b1;
        @(negedge clk); k2 = cyc; xfer_busy = 1'b0;
        expect_cmd(K_SRE, k2 + IDLE_SHORT + 1, "R11 restarted idle count");
        goto_cyc(k2 + IDLE_SHORT + 2);
        drained("R11");

        // Test F: mode-register load before self-refresh entry
        cfg_timeout = 2'd0; cfg_upd_policy = 2'd2; cfg_exit_refresh = 1'b1;
        do_reset(1'b1);
        emr_update_pending = 1'b1;
        @(negedge clk); k = cyc; xfer_busy = 1'b0;
        expect_cmd(K_MRS, k + 1, "R9 load before entry");
        expect_cmd(K_SRE, k + 2, "R9 entry after load");
        goto_cyc(k + 3);
        emr_update_pending = 1'b0;
        check("R9 in self-refresh after load", sr_done, 1);
        m = cyc; access_pending = 1'b1;
        expect_cmd(K_EXIT, m + 1, "R9 wake");
        expect_cmd(K_REF, m + 2 + T_XSNR, "R9 post refresh");
        goto_cyc(m + 3 + T_XSNR);
        p = cyc; access_pending = 1'b0;
        expect_cmd(K_SRE, p + 1, "R9 no load once cleared");
        goto_cyc(p + 2);
        drained("R9");

        // Test F2: shared-bus policy never loads before entry
        cfg_upd_policy = 2'd1;
        do_reset(1'b1);
        emr_update_pending = 1'b1;
        @(negedge clk); k = cyc; xfer_busy = 1'b0;
        expect_cmd(K_SRE, k + 1, "R9 policy 1 entry without load");
        goto_cyc(k + 2);
        emr_update_pending = 1'b0;
        drained("R9");

        // Test G: disabled mode codes, reserved timeout code
        cfg_mode = 2'd0; cfg_upd_policy = 2'd0;
        do_reset(1'b1);
        @(negedge clk); k = cyc; xfer_busy = 1'b0;
        goto_cyc(k + 200);
        check("R2 mode 0 keeps cke high", cke, 1);
        cfg_mode = 2'd3;
        goto_cyc(k + 400);
        check("R2 mode 3 keeps cke high", cke, 1);
        check("R2 mode 3 no self-refresh", sr_done, 0);
        k = cyc; cfg_mode = 2'd1; cfg_timeout = 2'd3;
        expect_cmd(K_SRE, k + 1, "R1 reserved timeout acts as 0");
        goto_cyc(k + 2);
        drained("R2");

        // Test H: periodic refresh interval
        cfg_mode = 2'd0; cfg_timeout = 2'd0;
        do_reset(1'b1);
        sb_on = 1'b0;
        ref_seen.delete();
        @(negedge clk); k = cyc; xfer_busy = 1'b0;
        goto_cyc(k + 2 * REFI_CYCLES + 10);
        check("R10 at least two refreshes", (ref_seen.size() >= 2) ? 1 : 0, 1);
        if (ref_seen.size() >= 2) begin
            check("R10 first refresh within interval", (ref_seen[0] - k <= REFI_CYCLES) ? 1 : 0, 1);
            check("R10 refresh interval", ref_seen[1] - ref_seen[0], REFI_CYCLES);
        end
        sb_on = 1'b1;

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule